// File: doc/BRIEF.md
# Banked Scratchpad Gather/Scatter Scheduler

This block serves one 32-lane memory instruction against a shared on-chip scratchpad. Every lane carries a byte address, a write flag and a 32-bit word. The storage is divided into word-wide banks that every lane can reach through a full crossbar. When several lanes need different words from one bank, the block splits the instruction into rounds. It serves what it can in each round and keeps the rest pending. Once every lane has been served, it returns the read words as a single 32-lane vector.

There are two storage arrays: a local one and a remote one. With the sharing bit low, the top address bit is ignored and every lane uses the local array. With the sharing bit high, the top address bit selects the remote array. Remote data waits in a fixed-length delay line before it can join the response. A requester drives a request with ready/valid and waits for the one-cycle response pulse. Only then is a new request taken.

Top module: `scratch_gather`

## Requirements
- R1: After reset, `req_ready` is 1 and `rsp_valid` is 0.
- R2: The byte address is split into fields. Bits [1:0] are ignored. Bits [BANK_W+1:2] give the bank (bits [6:2] with 32 banks). The next ROW_W bits give the row. The top bit selects the array. A request whose enabled lanes all use distinct banks finishes in one round.
- R3: In each round, the lowest-numbered pending lane claims each bank of each array, and lanes that need another word of a claimed bank stay pending. If all 32 lanes use one bank with 32 different rows, 32 rounds are needed.
- R4: A read lane that needs the same word as the read lane that claimed the bank is served in that same round, as a broadcast.
- R5: A write never shares a bank with another lane in the same round. A lane's access takes effect in the round it is served, so reads see writes from earlier rounds. When several lanes write one word, the highest-numbered of those lanes leaves its value.
- R6: The response is a one-cycle `rsp_valid` pulse. It carries the accepted lane mask on `rsp_lane_en`. `rsp_rdata` holds the read word for each enabled read lane and zero for write lanes and disabled lanes.
- R7: `req_ready` is high only in the idle state. It stays low from the accepting edge until the response pulse has ended, and it is high again in the cycle after the pulse.
- R8: When `mode_shared` is 0 at acceptance, the top address bit has no effect and every lane uses the local array.
- R9: When `mode_shared` is 1 at acceptance, lanes with the top address bit set use the remote array. The remote array is storage separate from the local array.
- R10: Let N be the number of rounds and F the last round that contains a remote lane (F = 0 if there is none). The response pulse appears max(N, F+FAR_LAT)+1 rising edges after the accepting edge.
- R11: A local lane and a remote lane on the same bank index never conflict with each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| mode_shared | input | 1 | Shared addressing: 1 lets the top address bit select the remote array |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block is idle and will take a request |
| req_lane_en | input | LANES | Per-lane enable |
| req_we | input | LANES | Per-lane write flag |
| req_addr | input | LANES*ADDR_W | Per-lane byte address, lane 0 in the low bits |
| req_wdata | input | LANES*32 | Per-lane write word |
| rsp_valid | output | 1 | One-cycle response pulse |
| rsp_lane_en | output | LANES | Lane mask of the request being answered |
| rsp_rdata | output | LANES*32 | Gathered read words |

## Verification
Assertions check several properties on every cycle. While lanes are still pending, each round retires at least one lane and no pending bit is ever set again. No bank gets two writes in one round. The response only fires with nothing pending and the remote delay line empty, and it lasts exactly one cycle. The bench's scenarios cover the rest. They show which lanes win each bank, that broadcast reads share a round, and the exact round count and latency for local and remote traffic. They also show that the top address bit is ignored in the default mode, and that the gathered data matches a lane-ordered model of both arrays.

// File: rtl/sg_pkg.sv
package sg_pkg;
  localparam int WORD_W = 32;
  localparam int BYTE_W = 2;

  typedef enum logic [1:0] {
    SG_IDLE = 2'd0,
    SG_RUN  = 2'd1,
    SG_DONE = 2'd2
  } sg_state_e;
endpackage

// File: rtl/sg_arbiter.sv
// Per-round bank arbitration: lowest pending lane claims its bank; matching
// reads ride along as a broadcast.
module sg_arbiter #(
  parameter int LANES  = 32,
  parameter int BANK_W = 5,
  parameter int ROW_W  = 4,
  localparam int IDX_W = $clog2(LANES)
) (
  input  logic [LANES-1:0]        pend,
  input  logic [LANES-1:0]        far,
  input  logic [LANES-1:0]        we,
  input  logic [LANES*BANK_W-1:0] bank,
  input  logic [LANES*ROW_W-1:0]  row,
  output logic [LANES-1:0]        grant
);
  logic [IDX_W-1:0] win [LANES];

  always_comb begin
    grant = '0;
    for (int i = 0; i < LANES; i++) begin
      win[i] = IDX_W'(i);
      for (int j = LANES - 1; j >= 0; j--) begin
        if (pend[j] && (far[j] == far[i]) &&
            (bank[j*BANK_W +: BANK_W] == bank[i*BANK_W +: BANK_W]))
          win[i] = IDX_W'(j);
      end
      if (pend[i]) begin
        if (win[i] == IDX_W'(i))
          grant[i] = 1'b1;
        else if (!we[i] && !we[win[i]] &&
                 (row[win[i]*ROW_W +: ROW_W] == row[i*ROW_W +: ROW_W]))
          grant[i] = 1'b1;
      end
    end
  end
endmodule

// File: rtl/sg_bank_array.sv
// One storage array of word-wide banks with a lane-to-bank crossbar.
module sg_bank_array
  import sg_pkg::*;
#(
  parameter int LANES  = 32,
  parameter int BANKS  = 32,
  parameter int ROW_W  = 4,
  localparam int BANK_W = $clog2(BANKS),
  localparam int ROWS   = 1 << ROW_W
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [LANES-1:0]        wr_en,
  input  logic [LANES*BANK_W-1:0] bank,
  input  logic [LANES*ROW_W-1:0]  row,
  input  logic [LANES*WORD_W-1:0] wdata,
  output logic [LANES*WORD_W-1:0] rdata
);
  logic [WORD_W-1:0] mem [BANKS][ROWS];

  always_ff @(posedge clk) begin
    for (int l = 0; l < LANES; l++) begin
      if (wr_en[l])
        mem[bank[l*BANK_W +: BANK_W]][row[l*ROW_W +: ROW_W]] <= wdata[l*WORD_W +: WORD_W];
    end
  end

  always_comb begin
    for (int l = 0; l < LANES; l++)
      rdata[l*WORD_W +: WORD_W] = mem[bank[l*BANK_W +: BANK_W]][row[l*ROW_W +: ROW_W]];
  end

  for (genvar b = 0; b < BANKS; b++) begin : g_bank_chk
    logic [LANES-1:0] hit;
    always_comb begin
      for (int l = 0; l < LANES; l++)
        hit[l] = wr_en[l] && (bank[l*BANK_W +: BANK_W] == BANK_W'(b));
    end
    // R5: a bank takes at most one write per round
    p_one_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(hit) <= 1);
  end
endmodule

// File: rtl/sg_far_delay.sv
// Fixed-length delay line for remote-array read data.
module sg_far_delay
  import sg_pkg::*;
#(
  parameter int LANES = 32,
  parameter int DEPTH = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  input  logic [LANES-1:0]        in_mask,
  input  logic [LANES*WORD_W-1:0] in_data,
  output logic                    out_valid,
  output logic [LANES-1:0]        out_mask,
  output logic [LANES*WORD_W-1:0] out_data,
  output logic                    busy
);
  logic [DEPTH-1:0]        v_q;
  logic [LANES-1:0]        m_q [DEPTH];
  logic [LANES*WORD_W-1:0] d_q [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) v_q <= '0;
    else        v_q <= {v_q[DEPTH-2:0], in_valid};
  end

  always_ff @(posedge clk) begin
    if (in_valid) begin
      m_q[0] <= in_mask;
      d_q[0] <= in_data;
    end
    for (int s = 1; s < DEPTH; s++) begin
      if (v_q[s-1]) begin
        m_q[s] <= m_q[s-1];
        d_q[s] <= d_q[s-1];
      end
    end
  end

  assign out_valid = v_q[DEPTH-1];
  assign out_mask  = m_q[DEPTH-1];
  assign out_data  = d_q[DEPTH-1];
  assign busy      = |v_q;
endmodule

// File: rtl/scratch_gather.sv
module scratch_gather
  import sg_pkg::*;
#(
  parameter int LANES   = 32,
  parameter int BANKS   = 32,
  parameter int ROW_W   = 4,
  parameter int FAR_LAT = 4,
  localparam int BANK_W = $clog2(BANKS),
  localparam int ADDR_W = ROW_W + BANK_W + BYTE_W + 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    mode_shared,
  input  logic                    req_valid,
  output logic                    req_ready,
  input  logic [LANES-1:0]        req_lane_en,
  input  logic [LANES-1:0]        req_we,
  input  logic [LANES*ADDR_W-1:0] req_addr,
  input  logic [LANES*WORD_W-1:0] req_wdata,
  output logic                    rsp_valid,
  output logic [LANES-1:0]        rsp_lane_en,
  output logic [LANES*WORD_W-1:0] rsp_rdata
);
  // reset: asserted asynchronously, released through two flops
  logic [1:0] rst_sync_q;
  logic       rst_n_i;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_i = rst_sync_q[1];

  sg_state_e               state_q, state_d;
  logic                    mode_q;
  logic [LANES-1:0]        en_q, we_q, pend_q, pend_d;
  logic [LANES*ADDR_W-1:0] addr_q;
  logic [LANES*WORD_W-1:0] wdata_q, res_q, res_d;
  logic                    accept, issue, pend_ce;

  logic [LANES*BANK_W-1:0] lane_bank;
  logic [LANES*ROW_W-1:0]  lane_row;
  logic [LANES-1:0]        lane_far, grant, grant_act;
  logic [LANES*WORD_W-1:0] arr_rd [2];
  logic                    fd_valid, fd_busy;
  logic [LANES-1:0]        fd_mask;
  logic [LANES*WORD_W-1:0] fd_data;

  assign req_ready = (state_q == SG_IDLE);
  assign accept    = req_valid && req_ready;
  assign issue     = (state_q == SG_RUN);
  assign pend_ce   = accept || issue;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [ADDR_W-1:0] a;
    assign a = addr_q[l*ADDR_W +: ADDR_W];
    assign lane_bank[l*BANK_W +: BANK_W] = a[BYTE_W +: BANK_W];
    assign lane_row[l*ROW_W +: ROW_W]    = a[BYTE_W+BANK_W +: ROW_W];
    assign lane_far[l] = mode_q && a[ADDR_W-1];
  end

  sg_arbiter #(.LANES(LANES), .BANK_W(BANK_W), .ROW_W(ROW_W)) u_arb (
    .pend(pend_q), .far(lane_far), .we(we_q),
    .bank(lane_bank), .row(lane_row), .grant(grant)
  );
  assign grant_act = issue ? grant : '0;

  for (genvar g = 0; g < 2; g++) begin : g_arr
    logic [LANES-1:0] sel;
    assign sel = (g == 0) ? ~lane_far : lane_far;
    sg_bank_array #(.LANES(LANES), .BANKS(BANKS), .ROW_W(ROW_W)) u_arr (
      .clk(clk), .rst_n(rst_n_i), .wr_en(grant_act & we_q & sel),
      .bank(lane_bank), .row(lane_row), .wdata(wdata_q), .rdata(arr_rd[g])
    );
  end

  sg_far_delay #(.LANES(LANES), .DEPTH(FAR_LAT)) u_far (
    .clk(clk), .rst_n(rst_n_i),
    .in_valid(|(grant_act & lane_far)),
    .in_mask(grant_act & lane_far & ~we_q),
    .in_data(arr_rd[1]),
    .out_valid(fd_valid), .out_mask(fd_mask), .out_data(fd_data), .busy(fd_busy)
  );

  // next state
  always_comb begin
    state_d = state_q;
    unique case (state_q)
      SG_IDLE: if (req_valid) state_d = SG_RUN;
      SG_RUN:  if ((pend_q == '0) && !fd_busy) state_d = SG_DONE;
      SG_DONE: state_d = SG_IDLE;
      default: state_d = SG_IDLE;
    endcase
  end

  always_comb begin
    pend_d = accept ? req_lane_en : (pend_q & ~grant_act);
    res_d  = res_q;
    if (accept) begin
      res_d = '0;
    end else begin
      for (int l = 0; l < LANES; l++) begin
        if (grant_act[l] && !lane_far[l] && !we_q[l])
          res_d[l*WORD_W +: WORD_W] = arr_rd[0][l*WORD_W +: WORD_W];
        if (fd_valid && fd_mask[l])
          res_d[l*WORD_W +: WORD_W] = fd_data[l*WORD_W +: WORD_W];
      end
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) begin
      state_q <= SG_IDLE;
      pend_q  <= '0;
    end else begin
      state_q <= state_d;
      if (pend_ce) pend_q <= pend_d;
    end
  end

  always_ff @(posedge clk) begin
    if (accept) begin
      mode_q  <= mode_shared;
      en_q    <= req_lane_en;
      we_q    <= req_we;
      addr_q  <= req_addr;
      wdata_q <= req_wdata;
    end
    if (pend_ce || fd_valid) res_q <= res_d;
  end

  assign rsp_valid   = (state_q == SG_DONE);
  assign rsp_lane_en = en_q;
  assign rsp_rdata   = res_q;

  // R7: a taken request closes the input until the response is done
  p_busy_after_accept_r7: assert property (@(posedge clk) disable iff (!rst_n_i)
    accept |=> !req_ready);
  // R6: the response lasts a single cycle
  p_rsp_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n_i)
    rsp_valid |=> !rsp_valid);
  // R3: every round retires at least one pending lane
  p_progress_r3: assert property (@(posedge clk) disable iff (!rst_n_i)
    (issue && (pend_q != '0)) |=> ($countones(pend_q) < $countones($past(pend_q))));
  // R3: pending lanes are never re-armed during a request
  p_no_rearm_r3: assert property (@(posedge clk) disable iff (!rst_n_i)
    issue |=> ((pend_q & ~$past(pend_q)) == '0));
  // R10: the response waits for every lane and for remote data in flight
  p_rsp_clean_r10: assert property (@(posedge clk) disable iff (!rst_n_i)
    rsp_valid |-> ((pend_q == '0) && !fd_busy));
endmodule

// File: tb/scratch_gather_bench.sv
module scratch_gather_bench;
  localparam int L  = 32;
  localparam int RW = 5;
  localparam int FL = 4;
  localparam int AW = RW + 5 + 3;

  logic            clk = 1'b0;
  logic            rst_n;
  logic            mode_shared, req_valid, req_ready, rsp_valid;
  logic [L-1:0]    req_lane_en, req_we, rsp_lane_en;
  logic [L*AW-1:0] req_addr;
  logic [L*32-1:0] req_wdata, rsp_rdata;

  always #10 clk = ~clk;   // 50 MHz

  scratch_gather #(.LANES(L), .BANKS(32), .ROW_W(RW), .FAR_LAT(FL)) u_scratch_gather (
    .clk(clk), .rst_n(rst_n), .mode_shared(mode_shared),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_lane_en(req_lane_en), .req_we(req_we), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_lane_en(rsp_lane_en), .rsp_rdata(rsp_rdata)
  );

  int n_chk = 0, n_fail = 0;
  logic [31:0]   m_mem [2][32][32];
  logic [L-1:0]  t_en, t_we;
  logic [AW-1:0] t_addr [L];
  logic [31:0]   t_wd [L];
  logic          t_mode;
  logic [31:0]   e_rd [L];
  int            e_lat;

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic logic [AW-1:0] mk(input int far, input int row, input int bank, input int low);
    mk = {far[0], row[RW-1:0], bank[4:0], low[1:0]};
  endfunction

  // Round-by-round model written from the requirements
  task automatic model();
    logic [L-1:0] pend;
    int rnd, lastfar, w, big;
    int bk [L];
    int rw [L];
    int fr [L];
    pend = t_en; rnd = 0; lastfar = 0;
    for (int l = 0; l < L; l++) begin
      bk[l] = int'(t_addr[l][6:2]);
      rw[l] = int'(t_addr[l][AW-2:7]);
      fr[l] = (t_mode && t_addr[l][AW-1]) ? 1 : 0;
      e_rd[l] = '0;
    end
    while (pend != '0) begin
      logic [L-1:0] g;
      g = '0; rnd++;
      for (int i = 0; i < L; i++) begin
        if (pend[i]) begin
          w = i;
          for (int j = 0; j < i; j++) begin
            if (pend[j] && fr[j] == fr[i] && bk[j] == bk[i]) begin w = j; break; end
          end
          if (w == i || (!t_we[i] && !t_we[w] && rw[w] == rw[i])) g[i] = 1'b1;
        end
      end
      for (int i = 0; i < L; i++)
        if (g[i] && !t_we[i]) e_rd[i] = m_mem[fr[i]][bk[i]][rw[i]];
      for (int i = 0; i < L; i++) begin
        if (g[i] && t_we[i]) m_mem[fr[i]][bk[i]][rw[i]] = t_wd[i];
        if (g[i] && fr[i] == 1) lastfar = rnd;
      end
      pend &= ~g;
    end
    big = (lastfar != 0) ? lastfar + FL : 0;
    e_lat = ((rnd > big) ? rnd : big) + 1;
  endtask

  task automatic do_req(input string tag_lat, input string tag_dat);
    int cyc;
    bit rdy_bad;
    model();
    @(negedge clk);
    req_valid = 1'b1; req_lane_en = t_en; req_we = t_we; mode_shared = t_mode;
    for (int l = 0; l < L; l++) begin
      req_addr[l*AW +: AW]  = t_addr[l];
      req_wdata[l*32 +: 32] = t_wd[l];
    end
    chk(req_ready == 1'b1, "R7", "ready when idle", 64'(req_ready), 64'd1);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    cyc = 0; rdy_bad = 1'b0;
    while (!rsp_valid && cyc < 300) begin
      if (req_ready) rdy_bad = 1'b1;
      @(negedge clk);
      cyc++;
    end
    chk(cyc == e_lat, tag_lat, "response latency", 64'(cyc), 64'(e_lat));
    chk(!rdy_bad, "R7", "ready low while busy", 64'(rdy_bad), 64'd0);
    chk(rsp_lane_en == t_en, "R6", "lane mask", 64'(rsp_lane_en), 64'(t_en));
    begin
      bit bad; int bl;
      bad = 1'b0; bl = 0;
      for (int l = 0; l < L; l++)
        if (!bad && rsp_rdata[l*32 +: 32] !== e_rd[l]) begin bad = 1'b1; bl = l; end
      chk(!bad, tag_dat, $sformatf("read data lane %0d", bl),
          64'(rsp_rdata[bl*32 +: 32]), 64'(e_rd[bl]));
    end
    @(negedge clk);
    chk(!rsp_valid && req_ready, "R6", "single pulse then ready",
        {62'd0, rsp_valid, req_ready}, 64'd1);
  endtask

  task automatic clear_req();
    t_en = '1; t_we = '0;
    for (int l = 0; l < L; l++) begin t_addr[l] = '0; t_wd[l] = $urandom; end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL R7 watchdog: actual timeout expected completion");
    report();
  end

  initial begin
    void'($urandom(32'd4242));
    rst_n = 1'b0; req_valid = 1'b0; mode_shared = 1'b0;
    req_lane_en = '0; req_we = '0; req_addr = '0; req_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(req_ready == 1'b1 && rsp_valid == 1'b0, "R1", "reset outputs",
        {62'd0, req_ready, rsp_valid}, 64'd2);

    // R2/R9: fill both arrays, one row per request, distinct banks -> one round
    for (int f = 0; f < 2; f++)
      for (int r = 0; r < 32; r++) begin
        clear_req(); t_we = '1; t_mode = 1'b1;
        for (int l = 0; l < L; l++) t_addr[l] = mk(f, r, l, 0);
        do_req("R2", "R9");
      end

    // R2: distinct banks, junk in bits [1:0]
    clear_req(); t_mode = 1'b1;
    for (int l = 0; l < L; l++) t_addr[l] = mk(l % 2, l, 31 - l, l);
    do_req("R2", "R2");

    // R3: worst case, one bank, 32 rows
    clear_req(); t_mode = 1'b0;
    for (int l = 0; l < L; l++) t_addr[l] = mk(0, l, 3, 0);
    do_req("R3", "R3");

    // R4: every lane reads one word -> broadcast in one round
    clear_req(); t_mode = 1'b0;
    for (int l = 0; l < L; l++) t_addr[l] = mk(0, 9, 7, l);
    do_req("R4", "R4");

    // R4/R3: lanes 0,2 same word, lane 1 other row of same bank -> two rounds
    clear_req(); t_mode = 1'b0; t_en = 32'h7;
    t_addr[0] = mk(0, 4, 2, 0); t_addr[1] = mk(0, 5, 2, 0); t_addr[2] = mk(0, 4, 2, 0);
    do_req("R4", "R4");

    // R5: four writes to one word, then a read of it
    clear_req(); t_mode = 1'b0; t_en = 32'hF; t_we = 32'hF;
    for (int l = 0; l < 4; l++) t_addr[l] = mk(0, 6, 11, 0);
    do_req("R5", "R5");
    clear_req(); t_mode = 1'b0; t_en = 32'h1; t_addr[0] = mk(0, 6, 11, 0);
    do_req("R5", "R5");

    // R8: default mode ignores top bit: write with it set, read local and remote
    clear_req(); t_mode = 1'b0; t_en = 32'h1; t_we = 32'h1; t_addr[0] = mk(1, 20, 5, 0);
    do_req("R8", "R8");
    clear_req(); t_mode = 1'b1; t_en = 32'h3;
    t_addr[0] = mk(0, 20, 5, 0); t_addr[1] = mk(1, 20, 5, 0);
    do_req("R10", "R8");

    // R10: single remote read
    clear_req(); t_mode = 1'b1; t_en = 32'h1; t_addr[0] = mk(1, 2, 2, 0);
    do_req("R10", "R9");

    // R11: local and remote lanes on the same bank in one round
    clear_req(); t_mode = 1'b1; t_en = 32'h3;
    t_addr[0] = mk(0, 1, 8, 0); t_addr[1] = mk(1, 3, 8, 0);
    do_req("R11", "R11");

    // R6: empty request
    clear_req(); t_mode = 1'b0; t_en = '0;
    do_req("R6", "R6");

    // Random mix: conflicts, broadcasts, writes, both modes
    for (int n = 0; n < 60; n++) begin
      clear_req();
      t_mode = ($urandom % 4) != 0;
      t_en = $urandom;
      for (int l = 0; l < L; l++) begin
        t_we[l] = ($urandom % 4) == 0;
        t_addr[l] = mk($urandom % 2, $urandom % 32, $urandom % 4, $urandom % 4);
      end
      do_req("R10", "R5");
    end
    report();
  end
endmodule